// File: doc/BRIEF.md
# Frame Flag Generator

This block runs beside the serial output of a descrambler that delivers one bit per clock of a 728-bit frame. It tracks which part of the frame each incoming bit belongs to. It then drives four flags, registered together with the data bit they describe. The frame is laid out as follows:

- 8 alignment-word bits
- 5 control bits
- 11 additional data bits
- 704 payload bits

A frame-start pulse marks bit 0. An alignment-valid input gates every flag. A two-bit mode selector and a channel select decide which payload bits count as valid.

On the output, the first two alignment-word bit periods carry the two control-information bits in place of the scrambled alignment word. This substitution only happens while alignment is valid. Frame parity (even/odd) is tracked so that mono transmissions, which carry different content in alternate frames, can be flagged correctly.

The position tracker is a state machine. Its states are:

- `ST_IDLE`: no frame reference since reset.
- `ST_ALIGN`: alignment word, positions 0 to 7.
- `ST_CTRL`: control bits, positions 8 to 12.
- `ST_ADDL`: additional data, positions 13 to 23.
- `ST_PAYLOAD`: payload, positions 24 to 727.

Its transitions are:

- Any state goes to `ST_ALIGN` at position 0 on a frame-start pulse.
- `ST_ALIGN` goes to `ST_CTRL` after position 7.
- `ST_CTRL` goes to `ST_ADDL` after position 12.
- `ST_ADDL` goes to `ST_PAYLOAD` after position 23.
- `ST_PAYLOAD` goes back to `ST_ALIGN` after position 727. This wrap also flips the frame parity.
- `ST_IDLE` stays put without a frame-start pulse.

Top module: `frame_flag_gen`

## Requirements
- R1: Reset clears all outputs. A sampled `frame_start` makes the bit sampled in that cycle position 0. Each later bit advances the position by one, and position 727 wraps to 0. Before the first `frame_start`, no flag is ever raised.
- R2: Frame parity is set to even (0) by `frame_start` and flips at every wrap from 727 to 0.
- R3: `flag_align_word` is high for positions 0 to 7 and for no other position.
- R4: `flag_cib` is high for positions 0 and 1 only. At position 0 `data_out` carries `ctrl_info[0]`, and at position 1 it carries `ctrl_info[1]`. At all other positions `data_out` equals `data_in`.
- R5: `flag_addl` is high for exactly positions 13 to 23. No flag is high at positions 8 to 12.
- R6: In stereo mode (`mode`=0), `flag_valid` is high on payload bit index k (k = position − 24) exactly when the least significant bit of k equals `chan_sel`.
- R7: In mono mode (`mode`=1), `flag_valid` is high on every payload bit of frames whose parity equals `chan_sel`, and low on all payload bits of the other frames.
- R8: In data mode (`mode`=2), `flag_valid` is high on all 704 payload bits. In mode 3 it is never high.
- R9: While `aligned` is low, every flag is low and `data_out` equals `data_in` with no substitution.
- R10: Every output describes the bit sampled at the previous rising edge: one register stage, no earlier and no later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the current input bit as frame position 0 |
| aligned | input | 1 | Alignment valid; low forces all flags low |
| mode | input | 2 | 0 stereo, 1 mono, 2 data, 3 no valid payload |
| chan_sel | input | 1 | Selected channel (slot parity or frame parity) |
| data_in | input | 1 | Descrambled serial data bit |
| ctrl_info | input | 2 | Control-information bits substituted at positions 0 and 1 |
| data_out | output | 1 | Registered data bit with substitution applied |
| flag_align_word | output | 1 | Alignment-word period flag |
| flag_cib | output | 1 | Control-information substitution flag |
| flag_addl | output | 1 | Additional-data period flag |
| flag_valid | output | 1 | Valid payload flag, mode dependent |

## Verification
Every output is due exactly one rising edge after the bit it describes is sampled. The driver sets inputs at the falling edge and queues the expected outputs for that bit. The monitor pops one entry 1 ns after each following rising edge and compares all five outputs at once. One check is made just after the stimulus that raises `frame_start` and before the edge that samples it. It confirms that nothing appears early, and the final empty-queue check confirms that nothing arrives late.

// File: rtl/flagen_pkg.sv
package flagen_pkg;

    // Frame field the current bit belongs to
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ALIGN   = 3'd1,
        ST_CTRL    = 3'd2,
        ST_ADDL    = 3'd3,
        ST_PAYLOAD = 3'd4
    } field_e;

    // Payload validity mode
    typedef enum logic [1:0] {
        MODE_STEREO = 2'd0,
        MODE_MONO   = 2'd1,
        MODE_DATA   = 2'd2,
        MODE_OFF    = 2'd3
    } dv_mode_e;

endpackage

// File: rtl/flagen_field_fsm.sv
module flagen_field_fsm
    import flagen_pkg::*;
#(
    parameter int FAW_LEN  = 8,
    parameter int CTRL_LEN = 5,
    parameter int ADDL_LEN = 11,
    parameter int PAY_LEN  = 704,
    localparam int HDR_LEN   = FAW_LEN + CTRL_LEN + ADDL_LEN,
    localparam int FRAME_LEN = HDR_LEN + PAY_LEN,
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    output field_e           cur_field,
    output logic [POS_W-1:0] cur_pos,
    output logic             cur_odd
);

    localparam logic [POS_W-1:0] ALIGN_LAST = POS_W'(FAW_LEN - 1);
    localparam logic [POS_W-1:0] CTRL_LAST  = POS_W'(FAW_LEN + CTRL_LEN - 1);
    localparam logic [POS_W-1:0] ADDL_LAST  = POS_W'(HDR_LEN - 1);
    localparam logic [POS_W-1:0] FRAME_LAST = POS_W'(FRAME_LEN - 1);

    field_e           field_q, nxt_field;
    logic [POS_W-1:0] pos_q, nxt_pos;
    logic             odd_q, nxt_odd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= ST_IDLE;
            pos_q   <= '0;
            odd_q   <= 1'b0;
        end else begin
            field_q <= nxt_field;
            pos_q   <= nxt_pos;
            odd_q   <= nxt_odd;
        end
    end

    // Next state: describes the bit sampled at this edge
    always_comb begin
        nxt_field = field_q;
        nxt_pos   = pos_q + POS_W'(1);
        nxt_odd   = odd_q;
        if (frame_start) begin
            nxt_field = ST_ALIGN;
            nxt_pos   = '0;
            nxt_odd   = 1'b0;
        end else begin
            unique case (field_q)
                ST_IDLE: begin
                    nxt_pos = '0;
                end
                ST_ALIGN: begin
                    if (pos_q == ALIGN_LAST) nxt_field = ST_CTRL;
                end
                ST_CTRL: begin
                    if (pos_q == CTRL_LAST) nxt_field = ST_ADDL;
                end
                ST_ADDL: begin
                    if (pos_q == ADDL_LAST) nxt_field = ST_PAYLOAD;
                end
                ST_PAYLOAD: begin
                    if (pos_q == FRAME_LAST) begin
                        nxt_field = ST_ALIGN;
                        nxt_pos   = '0;
                        nxt_odd   = ~odd_q;
                    end
                end
                default: begin
                    nxt_field = ST_IDLE;
                    nxt_pos   = '0;
                end
            endcase
        end
    end

    assign cur_field = nxt_field;
    assign cur_pos   = nxt_pos;
    assign cur_odd   = nxt_odd;

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= FRAME_LAST); // R1

    AST_WRAP_TO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q == ST_PAYLOAD && pos_q == FRAME_LAST && !frame_start)
        |=> (field_q == ST_ALIGN && pos_q == '0)); // R1

    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q == ST_PAYLOAD && pos_q == FRAME_LAST && !frame_start)
        |=> (odd_q != $past(odd_q))); // R2

    AST_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pos_q == '0 && !odd_q && field_q == ST_ALIGN)); // R2

endmodule

// File: rtl/flagen_dv_decode.sv
module flagen_dv_decode
    import flagen_pkg::*;
#(
    parameter int HDR_LEN = 24
) (
    input  field_e     field,
    input  logic       pos_lsb,
    input  logic       odd,
    input  logic [1:0] mode,
    input  logic       chan_sel,
    output logic       dv_raw
);

    localparam logic HDR_ODD = (HDR_LEN % 2) == 1;

    logic     slot_lsb;
    dv_mode_e mode_e;

    assign slot_lsb = pos_lsb ^ HDR_ODD;
    assign mode_e   = dv_mode_e'(mode);

    always_comb begin
        dv_raw = 1'b0;
        if (field == ST_PAYLOAD) begin
            unique case (mode_e)
                MODE_STEREO: dv_raw = (slot_lsb == chan_sel);
                MODE_MONO:   dv_raw = (odd == chan_sel);
                MODE_DATA:   dv_raw = 1'b1;
                MODE_OFF:    dv_raw = 1'b0;
                default:     dv_raw = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flagen_out_stage.sv
module flagen_out_stage
    import flagen_pkg::*;
#(
    parameter int POS_W    = 10,
    parameter int SUB_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  field_e              field,
    input  logic [POS_W-1:0]    pos,
    input  logic                aligned,
    input  logic                dv_raw,
    input  logic                data_in,
    input  logic [SUB_BITS-1:0] ctrl_info,
    output logic                data_out,
    output logic                flag_align_word,
    output logic                flag_cib,
    output logic                flag_addl,
    output logic                flag_valid
);

    logic [SUB_BITS-1:0] sub_hit;
    logic                sub_any;
    logic                sub_bit;

    for (genvar i = 0; i < SUB_BITS; i++) begin : g_sub
        assign sub_hit[i] = aligned && (field == ST_ALIGN) && (pos == POS_W'(i));
    end

    assign sub_any = |sub_hit;
    assign sub_bit = |(sub_hit & ctrl_info);

    // Output register: all results leave on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out        <= 1'b0;
            flag_align_word <= 1'b0;
            flag_cib        <= 1'b0;
            flag_addl       <= 1'b0;
            flag_valid      <= 1'b0;
        end else begin
            data_out        <= sub_any ? sub_bit : data_in;
            flag_align_word <= aligned && (field == ST_ALIGN);
            flag_cib        <= sub_any;
            flag_addl       <= aligned && (field == ST_ADDL);
            flag_valid      <= aligned && dv_raw;
        end
    end

endmodule

// File: rtl/frame_flag_gen.sv
module frame_flag_gen
    import flagen_pkg::*;
#(
    parameter int FAW_LEN  = 8,
    parameter int CTRL_LEN = 5,
    parameter int ADDL_LEN = 11,
    parameter int PAY_LEN  = 704,
    parameter int SUB_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                aligned,
    input  logic [1:0]          mode,
    input  logic                chan_sel,
    input  logic                data_in,
    input  logic [SUB_BITS-1:0] ctrl_info,
    output logic                data_out,
    output logic                flag_align_word,
    output logic                flag_cib,
    output logic                flag_addl,
    output logic                flag_valid
);

    localparam int HDR_LEN   = FAW_LEN + CTRL_LEN + ADDL_LEN;
    localparam int FRAME_LEN = HDR_LEN + PAY_LEN;
    localparam int POS_W     = $clog2(FRAME_LEN);

    field_e           cur_field;
    logic [POS_W-1:0] cur_pos;
    logic             cur_odd;
    logic             dv_raw;

    flagen_field_fsm #(
        .FAW_LEN (FAW_LEN),
        .CTRL_LEN(CTRL_LEN),
        .ADDL_LEN(ADDL_LEN),
        .PAY_LEN (PAY_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cur_field  (cur_field),
        .cur_pos    (cur_pos),
        .cur_odd    (cur_odd)
    );

    flagen_dv_decode #(
        .HDR_LEN(HDR_LEN)
    ) u_dv (
        .field   (cur_field),
        .pos_lsb (cur_pos[0]),
        .odd     (cur_odd),
        .mode    (mode),
        .chan_sel(chan_sel),
        .dv_raw  (dv_raw)
    );

    flagen_out_stage #(
        .POS_W   (POS_W),
        .SUB_BITS(SUB_BITS)
    ) u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .field          (cur_field),
        .pos            (cur_pos),
        .aligned        (aligned),
        .dv_raw         (dv_raw),
        .data_in        (data_in),
        .ctrl_info      (ctrl_info),
        .data_out       (data_out),
        .flag_align_word(flag_align_word),
        .flag_cib       (flag_cib),
        .flag_addl      (flag_addl),
        .flag_valid     (flag_valid)
    );

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |=> !(flag_align_word || flag_cib || flag_addl || flag_valid)); // R9

    AST_CIB_INSIDE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_cib |-> flag_align_word); // R4

    AST_FIELDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_align_word, flag_addl, flag_valid})); // R5

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_cib |-> (data_out == $past(data_in))); // R4

endmodule

// File: tb/frame_flag_gen_test.sv
`timescale 1ns/1ps
module frame_flag_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       aligned = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       chan_sel = 1'b0;
    logic       data_in = 1'b0;
    logic [1:0] ctrl_info = 2'b00;
    logic       data_out, flag_align_word, flag_cib, flag_addl, flag_valid;

    frame_flag_gen uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .aligned(aligned),
        .mode(mode), .chan_sel(chan_sel), .data_in(data_in), .ctrl_info(ctrl_info),
        .data_out(data_out), .flag_align_word(flag_align_word), .flag_cib(flag_cib),
        .flag_addl(flag_addl), .flag_valid(flag_valid)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [4:0] vec;   // {data, align_word, cib, addl, valid}
        logic [3:0] req;
        logic [9:0] pos;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    // configuration applied by the next driven bit
    logic       cfg_al = 1'b1;
    logic [1:0] cfg_mode = 2'd2;
    logic       cfg_sel = 1'b0;
    logic [1:0] cfg_cib = 2'b00;

    // reference frame model
    bit         m_valid = 1'b0;
    int         m_pos = 0;
    logic       m_odd = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string r, input logic [4:0] act, input logic [4:0] exp, input int pos);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", r, pos, act, exp);
        end
    endtask

    task automatic drive_bit(input logic fs, input logic din);
        exp_t e;
        logic fw, cb, ad, dv, d;
        int   k;
        @(negedge clk);
        frame_start = fs; data_in = din; aligned = cfg_al;
        mode = cfg_mode; chan_sel = cfg_sel; ctrl_info = cfg_cib;
        if (fs) begin
            m_valid = 1'b1; m_pos = 0; m_odd = 1'b0;
        end else if (m_valid) begin
            if (m_pos == 727) begin m_pos = 0; m_odd = ~m_odd; end
            else m_pos = m_pos + 1;
        end
        fw = 0; cb = 0; ad = 0; dv = 0; d = din;
        if (m_valid && cfg_al) begin
            fw = (m_pos < 8);
            cb = (m_pos < 2);
            ad = (m_pos >= 13 && m_pos < 24);
            if (m_pos >= 24) begin
                k = m_pos - 24;
                case (cfg_mode)
                    2'd0: dv = ((k % 2) == int'(cfg_sel));
                    2'd1: dv = (m_odd == cfg_sel);
                    2'd2: dv = 1'b1;
                    default: dv = 1'b0;
                endcase
            end
            if (m_pos < 2) d = cfg_cib[m_pos];
        end
        e.vec = {d, fw, cb, ad, dv};
        e.pos = 10'(m_pos);
        if (!m_valid)            e.req = 4'd1;  // R1
        else if (!cfg_al)        e.req = 4'd9;  // R9
        else if (m_pos < 2)      e.req = 4'd4;  // R4
        else if (m_pos < 8)      e.req = 4'd3;  // R3
        else if (m_pos < 24)     e.req = 4'd5;  // R5
        else if (cfg_mode == 0)  e.req = 4'd6;  // R6
        else if (cfg_mode == 1)  e.req = m_odd ? 4'd2 : 4'd7; // R2 / R7
        else                     e.req = 4'd8;  // R8
        sb_q.push_back(e);
    endtask

    task automatic run_bits(input int n, input bit fs_first);
        for (int i = 0; i < n; i++) begin
            drive_bit(fs_first && (i == 0), lfsr[0]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
    endtask

    // monitor: one result per rising edge, sampled 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(req_name(e.req),
                      {data_out, flag_align_word, flag_cib, flag_addl, flag_valid},
                      e.vec, int'(e.pos));
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL R10 watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", {data_out, flag_align_word, flag_cib, flag_addl, flag_valid}, 5'b0, 0);
        rst_n = 1'b1;

        // R1: no flags before the first frame start
        cfg_al = 1; cfg_mode = 2'd2;
        run_bits(20, 0);

        // R10: frame start bit driven, nothing visible before its edge
        cfg_cib = 2'b10;
        drive_bit(1'b1, 1'b1);
        #1;
        check("R10", {1'b0, flag_align_word, flag_cib, flag_addl, flag_valid}, 5'b0, 0);
        run_bits(727, 0);

        // R7 / R2: mono, channel 1, three frames by wrap (parity 1,0,1)
        cfg_mode = 2'd1; cfg_sel = 1'b1; cfg_cib = 2'b01;
        run_bits(728 * 3, 0);

        // R6: stereo both channels
        cfg_mode = 2'd0; cfg_sel = 1'b0; cfg_cib = 2'b11;
        run_bits(728, 0);
        cfg_sel = 1'b1; cfg_cib = 2'b00;
        run_bits(728, 0);

        // R8: mode off
        cfg_mode = 2'd3;
        run_bits(728, 0);

        // R9: alignment lost for a whole frame, substitution suppressed
        cfg_mode = 2'd2; cfg_al = 1'b0; cfg_cib = 2'b11;
        run_bits(728, 0);
        cfg_al = 1'b1;
        run_bits(300, 0);

        // R1 / R2: resync mid-frame, parity back to even, mono channel 0
        cfg_mode = 2'd1; cfg_sel = 1'b0; cfg_cib = 2'b10;
        run_bits(728, 1);
        run_bits(40, 0);

        repeat (3) @(negedge clk);
        // R10: no result left outstanding
        check("R10", {4'b0, sb_q.size() != 0}, 5'b0, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule